// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider for a Clock-Multiplying PLL

This block sits in the feedback path of a PLL that multiplies a 32 kHz-class reference up to tens of MHz. It runs on the fast output clock and emits one single-cycle feedback pulse per multiplier period. The phase detector compares that pulse with the reference edge. When the loop is locked, each reference period therefore lines up with exactly one feedback period.

The multiplier is set by two fields, a coarse count P and a fine count Q. The overall ratio is 2·(14·(P+1) + (Q+1)). A toggle stage halves the fast clock and enables a pulse-swallow counter on alternate cycles. That counter uses a 14/15 dual-modulus prescaler together with a main counter loaded with P+1 and a swallow counter loaded with Q+1. While the swallow count is nonzero the prescaler divides by 15, and after that it divides by 14. Both counters reload when the main count runs out, and only at that moment are the P and Q inputs taken in.

Settings that break the range rules are flagged on a validity output. They are also replaced by the smallest setting whose ratio lets the output move in steps of one reference period: P = 27, Q = 4, ratio 794.

Top module: `pll_fb_divider`

## Requirements
- R1: For a legal setting, successive rising feedback pulses are exactly 2·(14·(P+1)+Q+1) fast-clock cycles apart.
- R2: The first divide period after reset uses P = 71, Q = 3 regardless of the inputs, so the first pulse is high at the 2024th rising clock edge after reset is released.
- R3: The setting P = 27, Q = 4 gives a pulse spacing of 794 cycles.
- R4: `cfg_valid` is low whenever Q is below 2 or above 13.
- R5: `cfg_valid` is low whenever P is not greater than Q+1, and high when both this rule and the rule of R4 hold.
- R6: While `cfg_valid` is low, the divider runs with P = 27, Q = 4 (spacing 794).
- R7: `fb_pulse` is high for exactly one fast-clock cycle per period.
- R8: A change of P or Q during a period does not alter that period. The new ratio applies from the period that starts at the next pulse.
- R9: While reset is asserted, `fb_pulse` is low. Reset is active low and asynchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_sel | input | 8 | Coarse multiplier field P |
| q_sel | input | 4 | Fine multiplier field Q |
| fb_pulse | output | 1 | One-cycle feedback pulse, once per ratio period |
| cfg_valid | output | 1 | High when P and Q obey the range rules |

## Verification
The bench builds the divider with its default parameters: an 8-bit P field, a 4-bit Q field, reset defaults 71/3 and fallback 27/4. These widths reach every Q boundary (0, 1, 13, 14) and the largest ratio of 7196, so period lengths from 146 to 7196 cycles are measured at the pins. A vector table walks legal, minimum and rule-breaking settings, and checks both the period that is still running on the old setting and the first period on the new one. Directed runs check the reset default, a mid-period change and a reset that arrives mid-period.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
    // Lower modulus of the dual-modulus prescaler; the upper one is this plus one.
    localparam int PRE_LOW_MOD = 14;
    // Width of the prescaler down-counter (must hold PRE_LOW_MOD).
    localparam int PRE_W = $clog2(PRE_LOW_MOD + 1);

    typedef struct packed {
        logic phase;   // divide-by-two toggle, enables the swallow counter
        logic pulse;   // registered feedback pulse
    } top_state_t;
endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg
    import fbdiv_pkg::*;
#(
    parameter int PW    = 8,
    parameter int QW    = 4,
    parameter int MIN_P = 27,
    parameter int MIN_Q = 4
) (
    input  logic [PW-1:0] p_in,
    input  logic [QW-1:0] q_in,
    output logic [PW-1:0] p_eff,
    output logic [QW-1:0] q_eff,
    output logic          ok
);
    localparam int Q_MIN = 2;
    localparam int Q_MAX = PRE_LOW_MOD - 1;

    logic q_ok;
    logic p_ok;

    always_comb begin
        q_ok  = (int'(q_in) >= Q_MIN) && (int'(q_in) <= Q_MAX);
        p_ok  = int'(p_in) > (int'(q_in) + 1);
        ok    = q_ok && p_ok;
        p_eff = ok ? p_in : PW'(MIN_P);
        q_eff = ok ? q_in : QW'(MIN_Q);
    end
endmodule

// File: rtl/fbdiv_presc.sv
module fbdiv_presc
    import fbdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic long_next,   // next prescaler cycle divides by the upper modulus
    output logic tc           // last enabled count of the current prescaler cycle
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    assign tc = ce && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (tc) begin
            cnt_d = long_next ? PRE_W'(PRE_LOW_MOD) : PRE_W'(PRE_LOW_MOD - 1);
        end else if (ce) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Every loaded setting has a nonzero swallow count, so a period opens on the long modulus.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= PRE_W'(PRE_LOW_MOD);
        else        cnt_q <= cnt_d;
    end

    // R1
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PRE_W'(PRE_LOW_MOD));

    // R1
    pre_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (cnt_q >= PRE_W'(PRE_LOW_MOD - 1)));
endmodule

// File: rtl/fbdiv_cnt.sv
module fbdiv_cnt #(
    parameter int PW    = 8,
    parameter int QW    = 4,
    parameter int DEF_P = 71,
    parameter int DEF_Q = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tc,
    input  logic [PW-1:0] p_eff,
    input  logic [QW-1:0] q_eff,
    output logic          long_next,
    output logic          period_end
);
    localparam int MW = PW + 1;

    typedef struct packed {
        logic [MW-1:0] main;
        logic [QW-1:0] swl;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign period_end = tc && (st_q.main == MW'(1));

    always_comb begin
        st_d = st_q;
        if (period_end) begin
            // Settings are taken in only here, at the boundary between periods.
            st_d.main = MW'(p_eff) + MW'(1);
            st_d.swl  = q_eff + QW'(1);
        end else if (tc) begin
            st_d.main = st_q.main - MW'(1);
            if (st_q.swl != '0) st_d.swl = st_q.swl - QW'(1);
        end
        long_next = (st_d.swl != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.main <= MW'(DEF_P + 1);
            st_q.swl  <= QW'(DEF_Q + 1);
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    main_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.main != '0);

    // R1
    swallow_le_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        MW'(st_q.swl) <= st_q.main);
endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider
    import fbdiv_pkg::*;
#(
    parameter int PW    = 8,
    parameter int QW    = 4,
    parameter int DEF_P = 71,
    parameter int DEF_Q = 3,
    parameter int MIN_P = 27,
    parameter int MIN_Q = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] p_sel,
    input  logic [QW-1:0] q_sel,
    output logic          fb_pulse,
    output logic          cfg_valid
);
    top_state_t st_d, st_q;

    logic [PW-1:0] p_eff;
    logic [QW-1:0] q_eff;
    logic          tc;
    logic          long_next;
    logic          period_end;

    fbdiv_cfg #(.PW(PW), .QW(QW), .MIN_P(MIN_P), .MIN_Q(MIN_Q)) u_cfg (
        .p_in  (p_sel),
        .q_in  (q_sel),
        .p_eff (p_eff),
        .q_eff (q_eff),
        .ok    (cfg_valid)
    );

    fbdiv_presc u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (st_q.phase),
        .long_next (long_next),
        .tc        (tc)
    );

    fbdiv_cnt #(.PW(PW), .QW(QW), .DEF_P(DEF_P), .DEF_Q(DEF_Q)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tc         (tc),
        .p_eff      (p_eff),
        .q_eff      (q_eff),
        .long_next  (long_next),
        .period_end (period_end)
    );

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        st_d.pulse = period_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fb_pulse = st_q.pulse;

    // R7
    fb_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R6
    eff_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_eff) > 1) && (int'(q_eff) < PRE_LOW_MOD) && (int'(p_eff) > int'(q_eff) + 1));

    // R6
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (p_eff == PW'(MIN_P)) && (q_eff == QW'(MIN_Q)));
endmodule

// File: tb/pll_fb_divider_tb.sv
module pll_fb_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] p_sel = 8'd100;
    logic [3:0] q_sel = 4'd13;
    logic       fb_pulse;
    logic       cfg_valid;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pll_fb_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .p_sel     (p_sel),
        .q_sel     (q_sel),
        .fb_pulse  (fb_pulse),
        .cfg_valid (cfg_valid)
    );

    typedef struct packed {
        logic [7:0]  p;
        logic [3:0]  q;
        logic        ok;
        logic [15:0] ratio;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TAB [NV] = '{
        '{8'd71,  4'd3,  1'b1, 16'd2024},
        '{8'd27,  4'd4,  1'b1, 16'd794},
        '{8'd4,   4'd2,  1'b1, 16'd146},
        '{8'd100, 4'd13, 1'b1, 16'd2856},
        '{8'd15,  4'd13, 1'b1, 16'd476},
        '{8'd14,  4'd13, 1'b0, 16'd794},
        '{8'd50,  4'd1,  1'b0, 16'd794},
        '{8'd50,  4'd14, 1'b0, 16'd794},
        '{8'd200, 4'd7,  1'b1, 16'd5644},
        '{8'd255, 4'd13, 1'b1, 16'd7196},
        '{8'd0,   4'd0,  1'b0, 16'd794},
        '{8'd33,  4'd9,  1'b1, 16'd972}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts sampled cycles until the pulse is seen; the sample right after a pulse must be low.
    task automatic measure(input int start, output int n);
        n = start;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) check("R7 pulse width", int'(fb_pulse), 0);
        end while (fb_pulse !== 1'b1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 190000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n;
        int prev;
        // R9: reset state
        repeat (4) @(negedge clk);
        check("R9 reset pulse low", int'(fb_pulse), 0);
        check("R5 valid for 100/13", int'(cfg_valid), 1);

        // R2: first period uses the reset default even though inputs say 100/13
        rst_n = 1'b1;
        measure(0, n);
        check("R2 first period default", n, 2024);
        measure(0, n);
        check("R1 second period 100/13", n, 2856);
        prev = 2856;

        // Table: old period finishes unchanged (R8), then new ratio applies (R1 R6)
        for (int i = 0; i < NV; i++) begin
            p_sel = TAB[i].p;
            q_sel = TAB[i].q;
            #1;
            check("R4 R5 cfg_valid", int'(cfg_valid), int'(TAB[i].ok));
            measure(0, n);
            check("R8 old setting holds", n, prev);
            measure(0, n);
            if (TAB[i].p == 8'd27 && TAB[i].q == 4'd4)
                check("R3 minimum setting", n, int'(TAB[i].ratio));
            else if (!TAB[i].ok)
                check("R6 fallback ratio", n, int'(TAB[i].ratio));
            else
                check("R1 ratio", n, int'(TAB[i].ratio));
            prev = int'(TAB[i].ratio);
        end

        // R8: change in the middle of a period (running 33/9, 972 cycles)
        repeat (100) @(negedge clk);
        p_sel = 8'd4;
        q_sel = 4'd2;
        measure(100, n);
        check("R8 mid-period change", n, 972);
        measure(0, n);
        check("R1 after mid change", n, 146);

        // R9 then R2: reset arriving mid-period
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 pulse low in reset", int'(fb_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
        measure(0, n);
        check("R2 default after re-reset", n, 2024);
        measure(0, n);
        check("R1 inputs after re-reset", n, 146);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule